// File: doc/BRIEF.md
# Subroutine and Interrupt Stack Sequencer

This block runs the stack side of control transfers for an 8-bit processor core. It covers subroutine call and return, interrupt entry, software break, return from interrupt, and single-byte pushes and pulls of the accumulator or the status byte. It owns an 8-bit stack pointer. The stack lives in one fixed 256-byte page at the top of the address space and fills from high addresses to low ones. The block issues at most one byte-wide stack access per clock on a simple memory port.

The core presents a command code together with the program counter value for that command, a target address, the accumulator and the current status byte. The sequencer saves or restores the return address and flags in the order the processor defines. For a call it stores one less than the return address, and the matching return adds one back. An interrupt stores the exact resume address. A break resumes two bytes past its opcode. Each command occupies the fixed number of cycles that the processor spends on it. When the command ends, the new program counter, status and accumulator appear on registered outputs.

Top module: `stack_seq`

## Requirements
- R1: A push writes address {STACK_PAGE, SP} (STACK_PAGE = 0x01) and then SP decreases by one. A pull first increases SP by one and then reads {STACK_PAGE, SP}. SP is 8 bits wide and wraps modulo 256. It resets to 0xFD.
- R2: Call (code 0) uses cmd_pc as the address of the next instruction. It pushes cmd_pc-1, high byte first, sets pc_out to cmd_target and occupies 6 cycles.
- R3: Return (code 1) pulls the low byte first and then the high byte. It sets pc_out to the pulled address plus one, modulo 2^16, and occupies 6 cycles.
- R4: Interrupt (code 3) pushes cmd_pc high byte, then low byte, then the status byte with bit 4 (break) cleared. It sets status_out to that byte with bit 2 (interrupt disable) set and bit 3 (decimal) unchanged, sets pc_out to cmd_target and occupies 7 cycles.
- R5: Break (code 2) uses cmd_pc as the address of the break opcode. It pushes cmd_pc+2, high then low, then the status byte with bit 4 set. It sets status_out to that byte with bit 2 also set, sets pc_out to cmd_target and occupies 7 cycles.
- R6: Return from interrupt (code 4) pulls status, then low byte, then high byte. status_out becomes the pulled byte in full, pc_out becomes the pulled address with no increment, and the command occupies 6 cycles.
- R7: Push accumulator (code 5) and push status (code 6) write acc_in or status_in unchanged and occupy 3 cycles.
- R8: Pull accumulator (code 7) and pull status (code 8) place the pulled byte on acc_out or status_out and occupy 4 cycles.
- R9: A command is taken when cmd_valid is high and busy is low. busy then stays high for N-1 cycles, where N is the command's cycle count, and done pulses for the one cycle after that, in which the next command may be taken. Codes 9 to 15 are ignored: busy stays low, no access is made and SP does not change.
- R10: mem_we and mem_re are never high in the same cycle, so there is at most one stack access per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd | input | 4 | Command code |
| cmd_pc | input | 16 | Program counter value for the command |
| cmd_target | input | 16 | Call target or interrupt vector |
| acc_in | input | 8 | Accumulator value |
| status_in | input | 8 | Current status byte |
| mem_rdata | input | 8 | Stack read data for the address on mem_addr |
| busy | output | 1 | Command in progress |
| done | output | 1 | Results valid, single-cycle pulse |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 16 | Stack address |
| mem_wdata | output | 8 | Stack write data |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New status byte |
| acc_out | output | 8 | New accumulator |
| sp_out | output | 8 | Stack pointer |

## Verification
Call and return pairs run over program counters that include 0x0000 and 0xFFFF, so the minus-one on the pushed address and the plus-one on the return both have to wrap correctly. Interrupt and break are tried with status bytes that have every flag clear, every flag set, and the decimal flag alone. These separate break from interrupt by the pushed bit 4, and show that the decimal flag survives entry. A return from interrupt over a frame built by hand with pushes, carrying an odd status, shows that the whole status byte is replaced, that the address gets no increment and that the pull order is right. A run of 256 pushes and 256 pulls takes the pointer through both wrap points. Codes outside the table are offered to confirm that they are ignored.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  localparam int OP_W   = 4;
  localparam int STEP_W = 3;
  localparam int ST_I   = 2;
  localparam int ST_B   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CALL = 4'd0,
    OP_RET  = 4'd1,
    OP_BRK  = 4'd2,
    OP_IRQ  = 4'd3,
    OP_RTI  = 4'd4,
    OP_PHA  = 4'd5,
    OP_PHP  = 4'd6,
    OP_PLA  = 4'd7,
    OP_PLP  = 4'd8
  } stk_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd8;

  typedef enum logic [1:0] {ACC_NONE, ACC_PUSH, ACC_PULL} acc_kind_e;
  typedef enum logic [1:0] {SEL_HI, SEL_LO, SEL_ST, SEL_A} sel_e;
endpackage

// File: rtl/stk_plan.sv
`timescale 1ns/1ps
// Per-command access schedule: which access happens in which step, and the
// last step index (command cycle count minus one).
module stk_plan
  import stk_pkg::*;
(
  input  stk_op_e             op,
  input  logic [STEP_W-1:0]   idx,
  output acc_kind_e           kind,
  output sel_e                sel,
  output logic [STEP_W-1:0]   len_m1
);
  always_comb begin
    kind   = ACC_NONE;
    sel    = SEL_HI;
    len_m1 = STEP_W'(3);
    case (op)
      OP_CALL: begin
        len_m1 = STEP_W'(5);
        if (idx == STEP_W'(1)) begin kind = ACC_PUSH; sel = SEL_HI; end
        else if (idx == STEP_W'(2)) begin kind = ACC_PUSH; sel = SEL_LO; end
      end
      OP_RET: begin
        len_m1 = STEP_W'(5);
        if (idx == STEP_W'(1)) begin kind = ACC_PULL; sel = SEL_LO; end
        else if (idx == STEP_W'(2)) begin kind = ACC_PULL; sel = SEL_HI; end
      end
      OP_BRK, OP_IRQ: begin
        len_m1 = STEP_W'(6);
        if (idx == STEP_W'(1)) begin kind = ACC_PUSH; sel = SEL_HI; end
        else if (idx == STEP_W'(2)) begin kind = ACC_PUSH; sel = SEL_LO; end
        else if (idx == STEP_W'(3)) begin kind = ACC_PUSH; sel = SEL_ST; end
      end
      OP_RTI: begin
        len_m1 = STEP_W'(5);
        if (idx == STEP_W'(1)) begin kind = ACC_PULL; sel = SEL_ST; end
        else if (idx == STEP_W'(2)) begin kind = ACC_PULL; sel = SEL_LO; end
        else if (idx == STEP_W'(3)) begin kind = ACC_PULL; sel = SEL_HI; end
      end
      OP_PHA: begin
        len_m1 = STEP_W'(2);
        if (idx == STEP_W'(1)) begin kind = ACC_PUSH; sel = SEL_A; end
      end
      OP_PHP: begin
        len_m1 = STEP_W'(2);
        if (idx == STEP_W'(1)) begin kind = ACC_PUSH; sel = SEL_ST; end
      end
      OP_PLA: begin
        len_m1 = STEP_W'(3);
        if (idx == STEP_W'(1)) begin kind = ACC_PULL; sel = SEL_A; end
      end
      OP_PLP: begin
        len_m1 = STEP_W'(3);
        if (idx == STEP_W'(1)) begin kind = ACC_PULL; sel = SEL_ST; end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_frame.sv
`timescale 1ns/1ps
// Return address adjustment and the status byte that goes onto the stack.
module stk_frame
  import stk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  stk_op_e               op,
  input  logic [2*DATA_W-1:0]   pc,
  input  logic [DATA_W-1:0]     status,
  output logic [2*DATA_W-1:0]   ret_addr,
  output logic [DATA_W-1:0]     stat_push
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << ST_B;

  always_comb begin
    ret_addr  = pc;
    stat_push = status;
    case (op)
      OP_CALL: ret_addr = pc - ADDR_W'(1);
      OP_BRK: begin
        ret_addr  = pc + ADDR_W'(2);
        stat_push = status | B_MASK;
      end
      OP_IRQ:  stat_push = status & ~B_MASK;
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_sp.sv
`timescale 1ns/1ps
// Stack pointer: post-decrement on push, pre-increment on pull.
module stk_sp #(
  parameter int               SP_W     = 8,
  parameter logic [SP_W-1:0]  SP_RESET = 8'hFD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pull,
  output logic [SP_W-1:0]  sp,
  output logic [SP_W-1:0]  sp_up
);
  assign sp_up = sp + SP_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       sp <= SP_RESET;
    else if (push) sp <= sp - SP_W'(1);
    else if (pull) sp <= sp_up;
  end

  // R10: the sequencer never asks for both moves in one cycle
  assert_sp_single_move_R10: assert property (@(posedge clk) disable iff (rst)
    !(push && pull));
endmodule

// File: rtl/stack_seq.sv
`timescale 1ns/1ps
module stack_seq
  import stk_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter logic [DATA_W-1:0]  SP_RESET   = 8'hFD,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [OP_W-1:0]       cmd,
  input  logic [2*DATA_W-1:0]   cmd_pc,
  input  logic [2*DATA_W-1:0]   cmd_target,
  input  logic [DATA_W-1:0]     acc_in,
  input  logic [DATA_W-1:0]     status_in,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [2*DATA_W-1:0]   pc_out,
  output logic [DATA_W-1:0]     status_out,
  output logic [DATA_W-1:0]     acc_out,
  output logic [DATA_W-1:0]     sp_out
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << ST_I;

  stk_op_e            op_r, cur_op, cmd_op;
  logic [STEP_W-1:0]  step, nxt_idx, len_m1;
  acc_kind_e          kind;
  sel_e               sel, rd_sel;
  logic               cmd_ok, accept, issue, finish, do_push, do_pull, rd_pend;
  logic [ADDR_W-1:0]  adj_ret, ret_r, tgt_r, cur_ret;
  logic [DATA_W-1:0]  adj_stp, stp_r, sin_r, acc_r, cur_stp, cur_acc;
  logic [DATA_W-1:0]  lo_r, hi_r, st_pull, a_pull, push_data, sp_up;

  assign cmd_ok  = (cmd <= OP_LAST);
  assign accept  = cmd_valid && !busy && cmd_ok;
  assign cmd_op  = stk_op_e'(cmd);
  assign cur_op  = accept ? cmd_op : op_r;
  assign nxt_idx = accept ? STEP_W'(1) : step + STEP_W'(1);

  stk_plan u_plan (.op(cur_op), .idx(nxt_idx), .kind(kind), .sel(sel), .len_m1(len_m1));

  stk_frame #(.DATA_W(DATA_W)) u_frame (
    .op(cmd_op), .pc(cmd_pc), .status(status_in),
    .ret_addr(adj_ret), .stat_push(adj_stp));

  assign finish  = busy && (step == len_m1);
  assign issue   = accept || (busy && !finish);
  assign do_push = issue && (kind == ACC_PUSH);
  assign do_pull = issue && (kind == ACC_PULL);

  stk_sp #(.SP_W(DATA_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .push(do_push), .pull(do_pull),
    .sp(sp_out), .sp_up(sp_up));

  assign cur_ret = accept ? adj_ret : ret_r;
  assign cur_stp = accept ? adj_stp : stp_r;
  assign cur_acc = accept ? acc_in  : acc_r;

  always_comb begin
    case (sel)
      SEL_HI:  push_data = cur_ret[ADDR_W-1:DATA_W];
      SEL_LO:  push_data = cur_ret[DATA_W-1:0];
      SEL_ST:  push_data = cur_stp;
      default: push_data = cur_acc;
    endcase
  end

  // Sequencing and memory port
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; step <= '0; op_r <= OP_CALL;
      mem_we <= 1'b0; mem_re <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      rd_pend <= 1'b0; rd_sel <= SEL_HI;
      ret_r <= '0; tgt_r <= '0; stp_r <= '0; sin_r <= '0; acc_r <= '0;
      lo_r <= '0; hi_r <= '0; st_pull <= '0; a_pull <= '0;
      pc_out <= '0; status_out <= '0; acc_out <= '0;
    end else begin
      mem_we    <= do_push;
      mem_re    <= do_pull;
      mem_addr  <= {STACK_PAGE, (do_pull ? sp_up : sp_out)};
      mem_wdata <= push_data;
      rd_pend   <= do_pull;
      rd_sel    <= sel;
      done      <= finish;

      if (rd_pend) begin
        case (rd_sel)
          SEL_HI:  hi_r    <= mem_rdata;
          SEL_LO:  lo_r    <= mem_rdata;
          SEL_ST:  st_pull <= mem_rdata;
          default: a_pull  <= mem_rdata;
        endcase
      end

      if (accept) begin
        busy  <= 1'b1;
        step  <= STEP_W'(1);
        op_r  <= cmd_op;
        ret_r <= adj_ret;
        tgt_r <= cmd_target;
        stp_r <= adj_stp;
        sin_r <= status_in;
        acc_r <= acc_in;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= nxt_idx;
      end

      if (finish) begin
        pc_out     <= ret_r;
        status_out <= sin_r;
        acc_out    <= acc_r;
        case (op_r)
          OP_CALL: pc_out <= tgt_r;
          OP_RET:  pc_out <= {hi_r, lo_r} + ADDR_W'(1);
          OP_BRK, OP_IRQ: begin
            pc_out     <= tgt_r;
            status_out <= stp_r | I_MASK;
          end
          OP_RTI: begin
            pc_out     <= {hi_r, lo_r};
            status_out <= st_pull;
          end
          OP_PLA:  acc_out    <= a_pull;
          OP_PLP:  status_out <= st_pull;
          default: ;
        endcase
      end
    end
  end

  // R10: one access per cycle
  assert_one_access_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  // R1: every access stays in the stack page
  assert_stack_page_R1: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));
  // R1: a write sits one above the already-decremented pointer
  assert_push_post_dec_R1: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[DATA_W-1:0] == sp_up));
  // R1: a read uses the already-incremented pointer
  assert_pull_pre_inc_R1: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (mem_addr[DATA_W-1:0] == sp_out));
  // R9: done is a single-cycle pulse and never coincides with busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));
  // R9: unknown codes are ignored
  assert_ignore_code_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !cmd_ok) |=> (!busy && !mem_we && !mem_re));
  // Final pulled read is captured before results are formed
  assert_read_before_finish_R6: assert property (@(posedge clk) disable iff (rst)
    finish |-> !rd_pend);
  // R3: return resumes one past the pulled address
  assert_ret_plus_one_R3: assert property (@(posedge clk) disable iff (rst)
    (finish && op_r == OP_RET) |=> (pc_out == $past({hi_r, lo_r}) + ADDR_W'(1)));
  // R4: interrupt entry sets interrupt disable and keeps decimal
  assert_irq_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (finish && op_r == OP_IRQ) |=> (status_out[ST_I] && status_out[3] == $past(sin_r[3])));
endmodule

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic [15:0] cmd_pc = '0, cmd_target = '0;
  logic [7:0]  acc_in = '0, status_in = '0, mem_rdata;
  logic        busy, done, mem_we, mem_re;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, status_out, acc_out, sp_out;

  always #5 clk = ~clk;

  stack_seq u_stack_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_pc(cmd_pc),
    .cmd_target(cmd_target), .acc_in(acc_in), .status_in(status_in),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_out(pc_out), .status_out(status_out), .acc_out(acc_out), .sp_out(sp_out));

  logic [7:0] smem [256];
  assign mem_rdata = smem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;

  int n_vec = 0, n_bad = 0, n_acc = 0;
  logic [7:0] esp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Access monitor, sampled away from the clock edge
  always @(negedge clk) begin
    if (!rst && (mem_we || mem_re)) begin
      n_acc++;
      chk(!(mem_we && mem_re), "R10 read+write", {mem_we, mem_re}, 2'b00);
      chk(mem_addr[15:8] == 8'h01, "R1 page", mem_addr, {8'h01, mem_addr[7:0]});
    end
  end

  function automatic int len_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd4: return 6;
      4'd2, 4'd3:       return 7;
      4'd5, 4'd6:       return 3;
      default:          return 4;
    endcase
  endfunction

  task automatic run(input logic [3:0] c, input logic [15:0] pc, input logic [15:0] tgt,
                     input logic [7:0] a, input logic [7:0] st, input string req);
    int cyc;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cmd_pc = pc; cmd_target = tgt; acc_in = a; status_in = st;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == len_of(c), {req, " cycles R9"}, cyc, len_of(c));
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] pcs [6];
    logic [7:0]  sts [5];
    logic [15:0] r;
    logic [7:0]  v;
    int base;
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    pcs = '{16'h0000, 16'h1234, 16'h12FF, 16'h8000, 16'hFFFF, 16'h0100};
    sts = '{8'h00, 8'hFF, 8'h08, 8'hD3, 8'h14};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sp_out == 8'hFD, "R1 reset sp", sp_out, 8'hFD);
    chk(!busy && !done, "R9 reset idle", {busy, done}, 2'b00);
    chk(!mem_we && !mem_re, "R10 reset strobes", {mem_we, mem_re}, 2'b00);
    esp = 8'hFD;

    // R2 / R3: call and return over several return addresses
    foreach (pcs[k]) begin
      r = pcs[k] - 16'd1;
      run(4'd0, pcs[k], pcs[k] ^ 16'hA5C3, 8'h11, 8'h20, "R2");
      chk(pc_out == (pcs[k] ^ 16'hA5C3), "R2 target", pc_out, pcs[k] ^ 16'hA5C3);
      chk(smem[esp] == r[15:8], "R2 high pushed first", smem[esp], r[15:8]);
      chk(smem[8'(esp - 8'd1)] == r[7:0], "R2 low pushed second", smem[8'(esp - 8'd1)], r[7:0]);
      esp = esp - 8'd2;
      chk(sp_out == esp, "R1 sp after call", sp_out, esp);
      run(4'd1, 16'h0000, 16'h0000, 8'h00, 8'h00, "R3");
      chk(pc_out == pcs[k], "R3 return address", pc_out, pcs[k]);
      esp = esp + 8'd2;
      chk(sp_out == esp, "R1 sp after return", sp_out, esp);
    end

    // R4 / R6: interrupt entry and return
    foreach (sts[k]) begin
      r = 16'h4000 + {8'h00, sts[k]} * 16'd3;
      v = sts[k] & 8'hEF;
      run(4'd3, r, 16'hFFFE, 8'h00, sts[k], "R4");
      chk(pc_out == 16'hFFFE, "R4 vector", pc_out, 16'hFFFE);
      chk(smem[esp] == r[15:8], "R4 pc high", smem[esp], r[15:8]);
      chk(smem[8'(esp - 8'd1)] == r[7:0], "R4 pc low", smem[8'(esp - 8'd1)], r[7:0]);
      chk(smem[8'(esp - 8'd2)] == v, "R4 status pushed, bit4 clear", smem[8'(esp - 8'd2)], v);
      chk(status_out == (v | 8'h04), "R4 status out", status_out, v | 8'h04);
      chk(status_out[3] == sts[k][3], "R4 decimal kept", status_out[3], sts[k][3]);
      esp = esp - 8'd3;
      run(4'd4, 16'h0000, 16'h0000, 8'h00, 8'h00, "R6");
      chk(pc_out == r, "R6 exact address", pc_out, r);
      chk(status_out == v, "R6 status restored", status_out, v);
      esp = esp + 8'd3;
      chk(sp_out == esp, "R1 sp after rti", sp_out, esp);
    end

    // R5: break resumes two past the opcode
    foreach (sts[k]) begin
      r = 16'h2FFE + {8'h00, sts[k]};
      v = sts[k] | 8'h10;
      run(4'd2, r, 16'hFFFE, 8'h00, sts[k], "R5");
      chk(pc_out == 16'hFFFE, "R5 vector", pc_out, 16'hFFFE);
      chk(smem[esp] == 8'((r + 16'd2) >> 8), "R5 pc+2 high", smem[esp], 8'((r + 16'd2) >> 8));
      chk(smem[8'(esp - 8'd1)] == 8'(r + 16'd2), "R5 pc+2 low", smem[8'(esp - 8'd1)], 8'(r + 16'd2));
      chk(smem[8'(esp - 8'd2)] == v, "R5 status bit4 set", smem[8'(esp - 8'd2)], v);
      chk(status_out == (v | 8'h04), "R5 status out", status_out, v | 8'h04);
      esp = esp - 8'd3;
      run(4'd4, 16'h0000, 16'h0000, 8'h00, 8'h00, "R6");
      chk(pc_out == r + 16'd2, "R6 break return", pc_out, r + 16'd2);
      esp = esp + 8'd3;
    end

    // R6: hand-built frame, status replaced in full
    run(4'd5, 16'h0000, 16'h0000, 8'hBE, 8'h00, "R7");
    run(4'd5, 16'h0000, 16'h0000, 8'hEF, 8'h00, "R7");
    run(4'd5, 16'h0000, 16'h0000, 8'hC7, 8'h00, "R7");
    run(4'd4, 16'h0000, 16'h0000, 8'h00, 8'h00, "R6");
    chk(pc_out == 16'hBEEF, "R6 pull order", pc_out, 16'hBEEF);
    chk(status_out == 8'hC7, "R6 full status", status_out, 8'hC7);
    chk(sp_out == esp, "R1 sp balanced", sp_out, esp);

    // R7 / R8: status push and pull
    run(4'd6, 16'h0000, 16'h0000, 8'h00, 8'h9A, "R7");
    chk(smem[esp] == 8'h9A, "R7 status pushed", smem[esp], 8'h9A);
    esp = esp - 8'd1;
    run(4'd8, 16'h0000, 16'h0000, 8'h00, 8'h00, "R8");
    chk(status_out == 8'h9A, "R8 status pulled", status_out, 8'h9A);
    esp = esp + 8'd1;

    // R7 / R8 / R1: full pointer sweep through both wrap points
    for (int i = 0; i < 256; i++) begin
      v = 8'(i) ^ 8'h3C;
      run(4'd5, 16'h0000, 16'h0000, v, 8'h00, "R7");
      chk(smem[esp] == v, "R7 acc pushed", smem[esp], v);
      esp = esp - 8'd1;
      chk(sp_out == esp, "R1 sp push sweep", sp_out, esp);
    end
    for (int i = 255; i >= 0; i--) begin
      v = 8'(i) ^ 8'h3C;
      run(4'd7, 16'h0000, 16'h0000, 8'h00, 8'h00, "R8");
      chk(acc_out == v, "R8 acc pulled", acc_out, v);
      esp = esp + 8'd1;
      chk(sp_out == esp, "R1 sp pull sweep", sp_out, esp);
    end

    // R9: unknown codes ignored
    for (int c = 9; c < 16; c++) begin
      base = n_acc;
      @(negedge clk);
      cmd_valid = 1'b1; cmd = 4'(c);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(!busy, "R9 unknown not taken", busy, 1'b0);
      repeat (3) @(negedge clk);
      chk(!done, "R9 unknown no done", done, 1'b0);
      chk(n_acc == base, "R9 unknown no access", n_acc, base);
      chk(sp_out == esp, "R9 unknown sp kept", sp_out, esp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule